// File: doc/BRIEF.md
# Activity-Reloaded Watchdog Timer

This block is a down-counting watchdog for a chip that has to recover from a hung system without help. Software programs a timeout of up to 16 bits, or 8 bits in the narrow variant, and picks whether it counts seconds or minutes. The counter runs from a 1 Hz tick supplied from outside. In minute mode an internal prescaler divides that tick by sixty. Several external activity events can be enabled one by one to reload the counter with the programmed timeout, so a live system keeps the watchdog quiet just by working. The events are an infrared-receiver interrupt, a mouse interrupt, a keyboard interrupt and a read of a game port. A reload takes effect a fixed number of clock cycles after the event.

When the count reaches zero, or when software forces a timeout, the block pulses the reset outputs that are enabled for a fixed number of cycles and sets a sticky status flag. Software clears that flag. All setup goes through four byte-wide registers on a simple write bus. Reads are combinational and have no side effects.

Top module: `activity_watchdog`

## Requirements
- R1: After reset every register reads 0x00, both reset outputs are low and the interrupt-line output is 0.
- R2: The register at address 0 is control, address 1 is configuration, address 2 is the value low byte and address 3 is the value high byte. A write to address 3 only holds the high byte. A write to address 2 commits {held high, written low} as the timeout and loads it into the counter. Addresses 2 and 3 read back the live count.
- R3: Committing a timeout of zero stops the counter at 0. A stopped counter never expires and ignores activity events.
- R4: With configuration bit 7 = 1 the running count drops by one on each cycle in which `sec_tick` is high.
- R5: With configuration bit 7 = 0 the count drops by one on every 60th `sec_tick`. Each load and each reload restarts that divide-by-60 prescaler.
- R6: Control bit 7 enables the infrared event, bit 6 the mouse event, bit 5 the keyboard event and bit 4 the game-port read. An enabled event sampled at clock edge E reloads the running count with the committed timeout at edge E+RELOAD_DLY. An event whose bit is clear has no effect, and events that arrive while a reload is pending are ignored.
- R7: When a running count goes from 1 to 0 the counter stops and control bit 0 (status) becomes 1.
- R8: On expiry, `kbd_rst_o` goes high if configuration bit 6 is set and `pwr_rst_o` goes high if configuration bit 4 is set. Each stays high for exactly PULSE_W cycles, starting at the expiry edge.
- R9: A control write with bit 1 = 1 causes an expiry at that same edge, whatever the count. Control bit 1 always reads back as 0.
- R10: A control write with bit 0 = 0 clears the status flag. A control write with bit 0 = 1 leaves it unchanged.
- R11: Configuration bits 3:0 drive `irq_line_o`. All eight configuration bits read back as written.
- R12: With CNT_W = 8, writes to the high byte are ignored and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sec_tick | input | 1 | One-cycle pulse per second |
| ir_evt | input | 1 | Infrared-receiver interrupt event |
| mouse_evt | input | 1 | Mouse interrupt event |
| kbd_evt | input | 1 | Keyboard interrupt event |
| port_rd | input | 1 | Game-port read strobe |
| kbd_rst_o | output | 1 | Keyboard-reset pulse |
| pwr_rst_o | output | 1 | Power-good reset pulse |
| irq_line_o | output | 4 | Selected interrupt line number |

## Verification
The hardest state to reach is a minute-mode count whose prescaler is part-way through a minute at the moment a reload lands. Only the point at which the next decrement arrives shows whether the prescaler was cleared. The stimulus loads the timeout and issues 30 ticks. It then fires an enabled keyboard event and waits out the reload delay. After that it shows that 30 further ticks leave the count untouched and that a further 30 lower it by one. The exact reload cycle is checked separately: the count is sampled in the cycle before and the cycle after edge E+RELOAD_DLY.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CFG  = 2'd1,
    A_VLO  = 2'd2,
    A_VHI  = 2'd3
  } wdt_addr_e;

  localparam int CTL_STAT  = 0;
  localparam int CTL_FORCE = 1;
  localparam int CFG_SEC   = 7;
  localparam int CFG_KRST  = 6;
  localparam int CFG_PRST  = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             expire,
  input  logic [CNT_W-1:0] count,
  output logic [7:0]       rdata,
  output logic [3:0]       src_en,
  output logic             unit_sec,
  output logic             krst_en,
  output logic             prst_en,
  output logic [3:0]       irq_line,
  output logic             load_req,
  output logic [CNT_W-1:0] load_val,
  output logic             force_req
);
  logic [3:0] src_q, src_d;
  logic       stat_q, stat_d;
  logic [7:0] cfg_q, cfg_d;
  logic [7:0] rd_hi;
  logic       wr_ctl, wr_cfg;

  assign wr_ctl    = wr && (addr == A_CTRL);
  assign wr_cfg    = wr && (addr == A_CFG);
  assign load_req  = wr && (addr == A_VLO);
  assign force_req = wr_ctl && wdata[CTL_FORCE];

  generate
    if (CNT_W > 8) begin : g_wide
      logic [CNT_W-9:0] hi_q, hi_d;
      always_comb begin
        hi_d = hi_q;
        if (wr && (addr == A_VHI)) hi_d = wdata[CNT_W-9:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
      end
      assign load_val = {hi_q, wdata};
      assign rd_hi    = 8'(count[CNT_W-1:8]);
    end else begin : g_narrow
      assign load_val = wdata[CNT_W-1:0];
      assign rd_hi    = 8'h00;
    end
  endgenerate

  always_comb begin
    src_d  = src_q;
    cfg_d  = cfg_q;
    stat_d = stat_q;
    if (wr_ctl) begin
      src_d = wdata[7:4];
      if (!wdata[CTL_STAT]) stat_d = 1'b0;
    end
    if (expire) stat_d = 1'b1;
    if (wr_cfg) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      cfg_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      cfg_q  <= cfg_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {src_q, 3'b000, stat_q};
      A_CFG:   rdata = cfg_q;
      A_VLO:   rdata = count[7:0];
      default: rdata = rd_hi;
    endcase
  end

  assign src_en   = src_q;
  assign unit_sec = cfg_q[CFG_SEC];
  assign krst_en  = cfg_q[CFG_KRST];
  assign prst_en  = cfg_q[CFG_PRST];
  assign irq_line = cfg_q[3:0];

  // R7
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);
endmodule

// File: rtl/wdt_reload_delay.sv
module wdt_reload_delay #(
  parameter int RELOAD_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic fire
);
  localparam int DW = (RELOAD_DLY < 2) ? 1 : $clog2(RELOAD_DLY);

  logic          busy_q, busy_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  assign fire = busy_q && (dcnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    dcnt_d = dcnt_q;
    if (busy_q) begin
      if (fire) busy_d = 1'b0;
      else      dcnt_d = dcnt_q - 1'b1;
    end else if (trig) begin
      busy_d = 1'b1;
      dcnt_d = DW'(RELOAD_DLY - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      dcnt_q <= dcnt_d;
    end
  end

  // R6
  arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(trig));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 60,
  parameter int PULSE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             unit_sec,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic             force_req,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire,
  output logic             pulse_on
);
  localparam int PW  = $clog2(MIN_DIV);
  localparam int PCW = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, val_q, val_d;
  logic             run_q, run_d;
  logic [PW-1:0]    pre_q, pre_d;
  logic [PCW-1:0]   pls_q, pls_d;
  logic             unit_tick, reload_eff;

  always_comb begin
    reload_eff = reload && run_q;
    unit_tick  = sec_tick && (unit_sec || (pre_q == PW'(MIN_DIV - 1)));
    expire     = force_req ||
                 (run_q && unit_tick && (cnt_q == CNT_W'(1)) && !load_req && !reload_eff);
    cnt_d = cnt_q;
    run_d = run_q;
    val_d = val_q;
    if (force_req) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (load_req) begin
      val_d = load_val;
      cnt_d = load_val;
      run_d = |load_val;
    end else if (reload_eff) begin
      cnt_d = val_q;
    end else if (run_q && unit_tick) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_d = 1'b0;
    end
    if (load_req || reload_eff || unit_sec) pre_d = '0;
    else if (sec_tick) pre_d = (pre_q == PW'(MIN_DIV - 1)) ? '0 : pre_q + 1'b1;
    else pre_d = pre_q;
    if (expire)           pls_d = PCW'(PULSE_W);
    else if (pls_q != '0) pls_d = pls_q - 1'b1;
    else                  pls_d = pls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= '0;
      run_q <= 1'b0;
      pre_q <= '0;
      pls_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      val_q <= val_d;
      run_q <= run_d;
      pre_q <= pre_d;
      pls_q <= pls_d;
    end
  end

  assign count    = cnt_q;
  assign running  = run_q;
  assign pulse_on = (pls_q != '0);

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));
  // R4
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_req && !reload_eff) |=> (cnt_q <= $past(cnt_q)));
  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pls_q != '0) |-> $past(expire));
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
  parameter int CNT_W      = 16,
  parameter int MIN_DIV    = 60,
  parameter int PULSE_W    = 4,
  parameter int RELOAD_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  input  logic       ir_evt,
  input  logic       mouse_evt,
  input  logic       kbd_evt,
  input  logic       port_rd,
  output logic       kbd_rst_o,
  output logic       pwr_rst_o,
  output logic [3:0] irq_line_o
);
  logic [3:0]       src_en;
  logic             unit_sec, krst_en, prst_en;
  logic             load_req, force_req, expire, running, pulse_on;
  logic [CNT_W-1:0] load_val, count;
  logic             trig, fire;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .expire(expire), .count(count), .rdata(reg_rdata), .src_en(src_en),
    .unit_sec(unit_sec), .krst_en(krst_en), .prst_en(prst_en),
    .irq_line(irq_line_o), .load_req(load_req), .load_val(load_val),
    .force_req(force_req)
  );

  assign trig = running && |(src_en & {ir_evt, mouse_evt, kbd_evt, port_rd});

  wdt_reload_delay #(.RELOAD_DLY(RELOAD_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .trig(trig), .fire(fire)
  );

  wdt_countdown #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV), .PULSE_W(PULSE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .unit_sec(unit_sec),
    .load_req(load_req), .load_val(load_val), .reload(fire),
    .force_req(force_req), .count(count), .running(running),
    .expire(expire), .pulse_on(pulse_on)
  );

  assign kbd_rst_o = pulse_on && krst_en;
  assign pwr_rst_o = pulse_on && prst_en;
endmodule

// File: tb/activity_watchdog_test.sv
module activity_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       sec_tick = 1'b0, ir_evt = 1'b0, mouse_evt = 1'b0;
  logic       kbd_evt = 1'b0, port_rd = 1'b0;
  logic [7:0] rdata, rdata8;
  logic       kbd_rst, pwr_rst, kbd_rst8, pwr_rst8;
  logic [3:0] irq_line, irq_line8;
  int         n_run = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  activity_watchdog uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .sec_tick(sec_tick),
    .ir_evt(ir_evt), .mouse_evt(mouse_evt), .kbd_evt(kbd_evt),
    .port_rd(port_rd), .kbd_rst_o(kbd_rst), .pwr_rst_o(pwr_rst),
    .irq_line_o(irq_line)
  );

  activity_watchdog #(.CNT_W(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata8), .sec_tick(sec_tick),
    .ir_evt(ir_evt), .mouse_evt(mouse_evt), .kbd_evt(kbd_evt),
    .port_rd(port_rd), .kbd_rst_o(kbd_rst8), .pwr_rst_o(pwr_rst8),
    .irq_line_o(irq_line8)
  );

  // {cfg[55:48], value[47:32], ticks[31:24], expected count[23:8], expected status[7:0]}
  localparam logic [55:0] VEC [7] = '{
    {8'h80, 16'd10,     8'd3,  16'd7,      8'd0},
    {8'h80, 16'h0102,   8'd5,  16'h00FD,   8'd0},
    {8'h00, 16'd2,      8'd59, 16'd2,      8'd0},
    {8'h00, 16'd2,      8'd60, 16'd1,      8'd0},
    {8'h80, 16'd3,      8'd3,  16'd0,      8'd1},
    {8'h00, 16'd1,      8'd60, 16'd0,      8'd1},
    {8'h80, 16'h1000,   8'd0,  16'h1000,   8'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_count(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    c = {hi, lo};
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd3, v[15:8]);
    wr(2'd2, v[7:0]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), b);
      check("R1 reg", {8'h00, b}, 16'h0000);
    end
    check("R1 outs", {11'd0, kbd_rst, pwr_rst, irq_line}, 16'h0000);

    // vector table: R2 R4 R5 R7
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, VEC[i][55:48]);
      load(VEC[i][47:32]);
      ticks(int'(VEC[i][31:24]));
      rd_count(c);
      check("R2/R4/R5 count", c, VEC[i][23:8]);
      rd(2'd0, b);
      check("R7 status", {15'd0, b[0]}, {15'd0, VEC[i][0]});
    end

    // R11 configuration fields
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h8A);
    rd(2'd1, b);
    check("R11 cfg readback", {8'h00, b}, 16'h008A);
    check("R11 irq line", {12'd0, irq_line}, 16'h000A);

    // R6 exact reload timing, keyboard source
    wr(2'd0, 8'h20);
    load(16'd10);
    ticks(4);
    @(negedge clk); kbd_evt = 1'b1;
    @(negedge clk); kbd_evt = 1'b0;
    repeat (3) @(negedge clk);
    rd_count(c);
    check("R6 before reload", c, 16'd6);
    @(negedge clk);
    rd_count(c);
    check("R6 after reload", c, 16'd10);

    // R6 disabled mouse source ignored
    ticks(2);
    @(negedge clk); mouse_evt = 1'b1;
    @(negedge clk); mouse_evt = 1'b0;
    repeat (6) @(negedge clk);
    rd_count(c);
    check("R6 disabled source", c, 16'd8);

    // R6 game-port read source
    wr(2'd0, 8'h10);
    ticks(1);
    @(negedge clk); port_rd = 1'b1;
    @(negedge clk); port_rd = 1'b0;
    repeat (5) @(negedge clk);
    rd_count(c);
    check("R6 port read reload", c, 16'd10);

    // R6 infrared source
    wr(2'd0, 8'h80);
    ticks(3);
    @(negedge clk); ir_evt = 1'b1;
    @(negedge clk); ir_evt = 1'b0;
    repeat (5) @(negedge clk);
    rd_count(c);
    check("R6 ir reload", c, 16'd10);

    // R5 reload clears minute prescaler
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    load(16'd3);
    ticks(30);
    @(negedge clk); kbd_evt = 1'b1;
    @(negedge clk); kbd_evt = 1'b0;
    repeat (5) @(negedge clk);
    ticks(30);
    rd_count(c);
    check("R5 prescaler cleared", c, 16'd3);
    ticks(30);
    rd_count(c);
    check("R5 minute after reload", c, 16'd2);

    // R3 zero stops, events ignored
    wr(2'd1, 8'h80);
    load(16'd5);
    ticks(1);
    load(16'd0);
    ticks(3);
    @(negedge clk); kbd_evt = 1'b1;
    @(negedge clk); kbd_evt = 1'b0;
    repeat (6) @(negedge clk);
    rd_count(c);
    check("R3 stopped count", c, 16'd0);
    rd(2'd0, b);
    check("R3 no expiry", {15'd0, b[0]}, 16'd0);

    // R8 keyboard reset pulse width
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hC0);
    load(16'd1);
    ticks(1);
    check("R8 kbd pulse start", {14'd0, kbd_rst, pwr_rst}, 16'b10);
    repeat (3) @(negedge clk);
    check("R8 kbd pulse last", {15'd0, kbd_rst}, 16'd1);
    @(negedge clk);
    check("R8 kbd pulse end", {15'd0, kbd_rst}, 16'd0);

    // R10 status sticky / clear
    wr(2'd0, 8'h01);
    rd(2'd0, b);
    check("R10 write one keeps", {15'd0, b[0]}, 16'd1);
    wr(2'd0, 8'h00);
    rd(2'd0, b);
    check("R10 write zero clears", {15'd0, b[0]}, 16'd0);

    // R9 forced timeout with power-good pulse
    wr(2'd1, 8'h90);
    load(16'd50);
    wr(2'd0, 8'h02);
    check("R9 forced pulses", {14'd0, kbd_rst, pwr_rst}, 16'b01);
    rd(2'd0, b);
    check("R9 ctrl readback", {8'h00, b}, 16'h0001);
    rd_count(c);
    check("R9 count cleared", c, 16'd0);

    // R12 narrow variant
    repeat (6) @(negedge clk);
    load(16'h1234);
    reg_addr = 2'd2; #1;
    check("R12 narrow low", {8'h00, rdata8}, 16'h0034);
    reg_addr = 2'd3; #1;
    check("R12 narrow high", {8'h00, rdata8}, 16'h0000);
    rd_count(c);
    check("R2 wide commit", c, 16'h1234);

    finish_run();
  end
endmodule